// File: doc/BRIEF.md
# Flash Write Holding Buffer

This block stages bytes for a self-programming program memory. Each table-write command places one data byte into a holding block of `BLK_BYTES` bytes (8, 16, 32 or 64). Only the low `log2(BLK_BYTES)` bits of the table pointer choose the slot, so the upper pointer bits have no influence on where a byte lands.

A commit strobe hands the whole holding block to the memory side in a single wide transfer. The transfer address is the pointer with its slot bits forced to zero. After a commit, every holding byte returns to 0xFF. An erase strobe asks the memory side to clear the 64-byte region that contains the pointer. Erase always works on 64 bytes, whatever the write block size. Each accepted command raises `done` for exactly one cycle. A commit and an erase that arrive in the same cycle are refused: the block raises `err` and starts no memory operation. Programming timing and unlock handshakes are handled outside this block.

Top module: `flash_stage_buf`

## Requirements
- R1: After a synchronous active-low reset, `mem_wr`, `mem_erase`, `done` and `err` are 0 and every holding byte is 0xFF, so a first commit delivers all-0xFF data.
- R2: When `wr_en` is 1 at a clock edge, `wr_byte` is stored into slot `tbl_ptr[log2(BLK_BYTES)-1:0]`. The upper pointer bits have no effect, and a later write to the same slot replaces the earlier byte.
- R3: A commit alone (`commit`=1, `erase`=0) makes `mem_wr` 1 in the cycle after the edge. In that cycle `mem_data[8k+7:8k]` holds slot k, as it was before the commit edge.
- R4: The address of a commit is `tbl_ptr` with its low `log2(BLK_BYTES)` bits cleared.
- R5: After a commit, all holding bytes are 0xFF.
- R6: An erase alone makes `mem_erase` 1 in the cycle after the edge, with `mem_addr` equal to `tbl_ptr` with bits 5:0 cleared, for any block size. The holding block is left unchanged.
- R7: `done` is 1 for exactly the cycles in which `mem_wr` or `mem_erase` is 1, which is one cycle for each accepted command.
- R8: If `commit` and `erase` are both 1 at an edge, `err` is 1 for the next cycle, and `mem_wr`, `mem_erase` and `done` stay 0. The holding block is kept.
- R9: A write in the same cycle as a commit is left out of the committed data. It lands in the freshly cleared block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table-write strobe |
| commit | input | 1 | Commit-holding-block strobe |
| erase | input | 1 | Erase-64-byte-region strobe |
| tbl_ptr | input | PTR_W | Table pointer |
| wr_byte | input | 8 | Latch byte to be staged |
| mem_wr | output | 1 | Block-write pulse to the memory |
| mem_erase | output | 1 | Erase pulse to the memory |
| mem_addr | output | PTR_W | Aligned address for the memory operation |
| mem_data | output | 8*BLK_BYTES | Block contents for the block write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command-clash pulse |

## Verification
Slot indexing is tried by filling the block with writes whose upper pointer bits vary. This separates correct low-bit decoding from any dependence on the high bits. Writing the same slot twice shows that the last write wins. Back-to-back commits show the 0xFF refill after a commit. Erases with non-zero low pointer bits tell the fixed 64-byte alignment apart from block-size alignment, and a following commit shows the staged data is kept. A long pseudo-random stretch mixes every strobe combination, including clashes and writes coinciding with commits, against a behavioural model on every cycle.

// File: rtl/fsb_pkg.sv
// Shared definitions for the flash write holding buffer.
// Assumes a byte-organised program memory with fixed 64-byte erase regions.
package fsb_pkg;
    localparam int unsigned ERASE_BYTES = 64;
    localparam int unsigned ERASE_LOG2  = 6;

    // Command class decided from the two strobes of one cycle.
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_COMMIT = 2'd1,
        OP_ERASE  = 2'd2,
        OP_CLASH  = 2'd3
    } fsb_op_e;
endpackage

// File: rtl/fsb_decode.sv
// Turns the commit and erase strobes into one command class.
// Assumes both strobes are sampled in the same cycle; together they form a clash.
module fsb_decode
    import fsb_pkg::*;
(
    input  logic    commit,
    input  logic    erase,
    output fsb_op_e op
);
    // Purpose: classify the strobe pair.
    always_comb begin
        unique case ({commit, erase})
            2'b10:   op = OP_COMMIT;
            2'b01:   op = OP_ERASE;
            2'b11:   op = OP_CLASH;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/fsb_hold.sv
// Holding-register block: BLK_BYTES byte slots, each written when its index matches.
// Assumes a clear and a write can share a cycle; the write then lands in the
// cleared block.
module fsb_hold #(
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned IDX_W     = $clog2(BLK_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_byte,
    input  logic                   clear,
    output logic [BLK_BYTES*8-1:0] hold_flat
);
    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        logic [7:0] slot_q;

        // Purpose: refill the slot on reset or clear; a matching write takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= 8'hFF;
            end else begin
                if (clear) slot_q <= 8'hFF;
                if (wr_en && (wr_idx == SLOT)) slot_q <= wr_byte;
            end
        end

        assign hold_flat[8*g +: 8] = slot_q;
    end
endmodule

// File: rtl/fsb_issue.sv
// Issues registered memory-side operations and the done/error pulses.
// Assumes the holding data presented here is the pre-clear content of the block.
module fsb_issue
    import fsb_pkg::*;
#(
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned PTR_W     = 22
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  fsb_op_e                op,
    input  logic [PTR_W-1:0]       ptr,
    input  logic [BLK_BYTES*8-1:0] hold_flat,
    output logic                   mem_wr,
    output logic                   mem_erase,
    output logic [PTR_W-1:0]       mem_addr,
    output logic [BLK_BYTES*8-1:0] mem_data,
    output logic                   done,
    output logic                   err
);
    localparam logic [PTR_W-1:0] BLK_MASK   = ~PTR_W'(BLK_BYTES - 1);
    localparam logic [PTR_W-1:0] ERASE_MASK = ~PTR_W'(ERASE_BYTES - 1);

    // Purpose: register the operation pulses for one cycle per command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr    <= 1'b0;
            mem_erase <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            mem_wr    <= (op == OP_COMMIT);
            mem_erase <= (op == OP_ERASE);
            done      <= (op == OP_COMMIT) || (op == OP_ERASE);
            err       <= (op == OP_CLASH);
        end
    end

    // Purpose: capture the aligned address and block data of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_data <= '1;
        end else begin
            case (op)
                OP_COMMIT: begin
                    mem_addr <= ptr & BLK_MASK;
                    mem_data <= hold_flat;
                end
                OP_ERASE: mem_addr <= ptr & ERASE_MASK;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_stage_buf.sv
// Top of the flash write holding buffer: table writes stage bytes, commit
// hands over the block, erase requests a 64-byte clear.
// Assumes BLK_BYTES is 8, 16, 32 or 64 and PTR_W covers the memory space.
module flash_stage_buf
    import fsb_pkg::*;
#(
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned PTR_W     = 22
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   commit,
    input  logic                   erase,
    input  logic [PTR_W-1:0]       tbl_ptr,
    input  logic [7:0]             wr_byte,
    output logic                   mem_wr,
    output logic                   mem_erase,
    output logic [PTR_W-1:0]       mem_addr,
    output logic [BLK_BYTES*8-1:0] mem_data,
    output logic                   done,
    output logic                   err
);
    localparam int unsigned IDX_W = $clog2(BLK_BYTES);

    fsb_op_e                op;
    logic [BLK_BYTES*8-1:0] hold_flat;

    fsb_decode u_decode (
        .commit (commit),
        .erase  (erase),
        .op     (op)
    );

    fsb_hold #(.BLK_BYTES(BLK_BYTES), .IDX_W(IDX_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (tbl_ptr[IDX_W-1:0]),
        .wr_byte   (wr_byte),
        .clear     (op == OP_COMMIT),
        .hold_flat (hold_flat)
    );

    fsb_issue #(.BLK_BYTES(BLK_BYTES), .PTR_W(PTR_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ptr       (tbl_ptr),
        .hold_flat (hold_flat),
        .mem_wr    (mem_wr),
        .mem_erase (mem_erase),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .done      (done),
        .err       (err)
    );
endmodule

// File: rtl/flash_stage_buf_chk.sv
// Property checker for flash_stage_buf, attached by bind.
// Assumes IDX_W is at most 6, so the erase alignment covers the slot bits.
module flash_stage_buf_chk #(
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned PTR_W     = 22,
    parameter int unsigned IDX_W     = $clog2(BLK_BYTES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   commit,
    input logic                   erase,
    input logic [PTR_W-1:IDX_W]   ptr_hi,
    input logic                   mem_wr,
    input logic                   mem_erase,
    input logic [PTR_W-1:0]       mem_addr,
    input logic                   done,
    input logic                   err
);
    a_r7_done_after_single: assert property (@(posedge clk) disable iff (!rst_n)
        (commit ^ erase) |=> done);

    a_r7_done_with_op: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_wr || mem_erase));

    a_r8_clash_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && erase) |=> (err && !done && !mem_wr && !mem_erase));

    a_r8_exclusive_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_erase, err}));

    a_r4_commit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[IDX_W-1:0] == '0));

    a_r4_commit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !erase) |=> (mem_addr[PTR_W-1:IDX_W] == $past(ptr_hi)));

    a_r6_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |-> (mem_addr[5:0] == 6'd0));

    a_r6_erase_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (erase && !commit) |=> (mem_addr[PTR_W-1:6] == $past(ptr_hi[PTR_W-1:6])));
endmodule

bind flash_stage_buf flash_stage_buf_chk #(.BLK_BYTES(BLK_BYTES), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .erase     (erase),
    .ptr_hi    (tbl_ptr[PTR_W-1:$clog2(BLK_BYTES)]),
    .mem_wr    (mem_wr),
    .mem_erase (mem_erase),
    .mem_addr  (mem_addr),
    .done      (done),
    .err       (err)
);

// File: tb/flash_stage_buf_test.sv
// Bench for flash_stage_buf: a behavioural byte-array model checked every cycle.
module flash_stage_buf_test;
    localparam int BLK   = 16;
    localparam int PTR_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, commit = 1'b0, erase = 1'b0;
    logic [PTR_W-1:0] tbl_ptr = '0;
    logic [7:0] wr_byte = '0;
    logic mem_wr, mem_erase, done, err;
    logic [PTR_W-1:0] mem_addr;
    logic [BLK*8-1:0] mem_data;

    int unsigned n_chk = 0, n_bad = 0;

    // Reference state
    logic [7:0] m_hold [BLK];
    logic e_wr, e_er, e_err, e_done;
    logic [PTR_W-1:0] e_addr;
    logic [BLK*8-1:0] e_data;

    flash_stage_buf #(.BLK_BYTES(BLK), .PTR_W(PTR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .commit(commit), .erase(erase),
        .tbl_ptr(tbl_ptr), .wr_byte(wr_byte), .mem_wr(mem_wr), .mem_erase(mem_erase),
        .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string scen,
                         input logic [BLK*8-1:0] act, input logic [BLK*8-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (scenario %s): actual %h expected %h", tag, scen, act, exp);
        end
    endtask

    task automatic model_edge();
        bit c = commit && !erase;
        bit e = erase && !commit;
        if (!rst_n) begin
            foreach (m_hold[k]) m_hold[k] = 8'hFF;
            e_wr = 0; e_er = 0; e_err = 0; e_done = 0;
            return;
        end
        e_wr = c; e_er = e; e_err = commit && erase; e_done = c || e;
        if (c) begin
            e_addr = tbl_ptr & ~PTR_W'(BLK - 1);
            for (int k = 0; k < BLK; k++) e_data[8*k +: 8] = m_hold[k];
            foreach (m_hold[k]) m_hold[k] = 8'hFF;
        end
        if (e) e_addr = tbl_ptr & ~PTR_W'(63);
        if (wr_en) m_hold[tbl_ptr % BLK] = wr_byte;
    endtask

    task automatic compare(input string scen);
        check(mem_wr == e_wr, "R3 mem_wr", scen, BLK*8'(mem_wr), BLK*8'(e_wr));
        check(mem_erase == e_er, "R6 mem_erase", scen, BLK*8'(mem_erase), BLK*8'(e_er));
        check(done == e_done, "R7 done", scen, BLK*8'(done), BLK*8'(e_done));
        check(err == e_err, "R8 err", scen, BLK*8'(err), BLK*8'(e_err));
        if (e_wr) begin
            check(mem_addr == e_addr, "R4 addr", scen, BLK*8'(mem_addr), BLK*8'(e_addr));
            check(mem_data == e_data, "R3 data", scen, mem_data, e_data);
        end
        if (e_er)
            check(mem_addr == e_addr, "R6 addr", scen, BLK*8'(mem_addr), BLK*8'(e_addr));
    endtask

    task automatic cyc(input bit we, input bit cm, input bit er,
                       input logic [PTR_W-1:0] p, input logic [7:0] d, input string scen);
        wr_en = we; commit = cm; erase = er; tbl_ptr = p; wr_byte = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(scen);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2357;
        // R1: reset state
        rst_n = 1'b0;
        cyc(0, 0, 0, '0, '0, "R1 reset");
        cyc(0, 0, 0, '0, '0, "R1 reset");
        rst_n = 1'b1;
        cyc(0, 1, 0, 22'h01_2345, 8'h00, "R1 first commit all FF");
        cyc(0, 0, 0, '0, '0, "R1 idle");

        // R2: fill every slot with varied upper pointer bits; R3/R4 commit
        for (int i = 0; i < BLK; i++)
            cyc(1, 0, 0, PTR_W'(i) | PTR_W'((i * 37) << 4), 8'(8'h30 + i), "R2 fill");
        cyc(1, 0, 0, 22'h3F_FFF3, 8'hA5, "R2 overwrite slot 3");
        cyc(0, 1, 0, 22'h2A_BCDE, 8'h00, "R3 R4 commit");
        // R5: second commit shows refill
        cyc(0, 1, 0, 22'h00_0017, 8'h00, "R5 refilled");

        // R6: erase alignment independent of block size, holding kept
        cyc(1, 0, 0, 22'h00_0002, 8'h5A, "R6 stage");
        cyc(0, 0, 1, 22'h15_5575, 8'h00, "R6 erase");
        cyc(0, 1, 0, 22'h00_0000, 8'h00, "R6 hold kept");

        // R8: clash, holding kept
        cyc(1, 0, 0, 22'h00_0009, 8'h99, "R8 stage");
        cyc(0, 1, 1, 22'h11_1111, 8'h00, "R8 clash");
        cyc(0, 1, 0, 22'h00_0040, 8'h00, "R8 hold kept");

        // R9: write coinciding with commit lands in new block
        cyc(1, 0, 0, 22'h00_0001, 8'h11, "R9 stage");
        cyc(1, 1, 0, 22'h00_0004, 8'h44, "R9 write with commit");
        cyc(0, 1, 0, 22'h00_0000, 8'h00, "R9 new block");

        // Mixed pseudo-random traffic
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[0], lfsr[5:3] == 3'd0, lfsr[9:7] == 3'd0,
                PTR_W'(lfsr[31:10]), lfsr[17:10], "R7 mixed");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule